// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the array address for each beat of a four-beat burst. A starting address is captured from the external address bus whenever either of two active-low load strobes is low at a clock edge. The upper address bits are then held, and the two lowest bits step through one beat per clock edge. A beat is taken only on edges where the active-low step input is low.

A static mode pin picks the beat order. Low selects linear order, where the low bits count upward from the start and wrap inside the aligned four-beat block. High selects interleaved order, where the low bits are the start bits XOR the beat number. The intended tie-off for this pin is high, so interleaved order is the default.

Any edge may load a fresh address, so a host that never steps gets plain single-cycle random access. The two strobes share the address bus. When both are low together, the processor-side strobe is granted, and the result is the same load. The output is a register-fed combinational value that drives the array directly. There is no handshake, because every address is accepted on the edge that presents it.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr_o` is all zeros.
- R2: When `cpu_ld_n` is low at a rising edge, `addr_o` equals the `addr_i` value from that edge, starting just after the edge.
- R3: When `ctl_ld_n` is low at a rising edge, `addr_o` equals the sampled `addr_i` after the edge. This also holds when both strobes are low, and a load takes precedence over a low `adv_n` on the same edge.
- R4: On an edge with both strobes high, bits `[ADDR_W-1:2]` of `addr_o` keep their value.
- R5: On an edge with both strobes high and `adv_n` high, `addr_o` keeps its value if `order_lin_n` is also unchanged.
- R6: With `order_lin_n` = 0 (linear), the low two bits on beat n equal (start + n) mod 4.
- R7: With `order_lin_n` = 1 (interleaved), the low two bits on beat n equal start XOR n.
- R8: The beat count is n = 0 at a load and rises by one per step edge, modulo 4. After the fourth step the address is back at the start, and further steps repeat the same cycle.
- R9: Loads on consecutive edges each take effect, so every edge can present a new unrelated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ld_n | input | 1 | Processor-side load strobe, active low, higher priority |
| ctl_ld_n | input | 1 | Controller-side load strobe, active low |
| adv_n | input | 1 | Beat step enable, active low |
| order_lin_n | input | 1 | Order select: 0 = linear, 1 = interleaved (tie high by default) |
| addr_i | input | ADDR_W | External starting address |
| addr_o | output | ADDR_W | Address presented to the array |

## Verification
The bench targets wrap-around in both orders, from every starting offset. A linear counter that carried into the upper bits would corrupt bit 2, and an interleaved map built with addition instead of XOR would go wrong from starts 1 and 3. It also drives strobes together with a low step input on the same edge; a design that let the step win would show start plus one instead of the loaded address. Back-to-back loads and long idle gaps inside a burst are mixed in, so a counter that ran free or ignored a load would drift from the reference. Toggling the order pin mid-burst checks that the beat count is kept separately from the order mapping.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Ordering applied to the low address bits
  typedef enum logic {
    SEQ_LINEAR     = 1'b0,
    SEQ_INTERLEAVE = 1'b1
  } seq_order_e;

  // Which strobe was granted on a load edge
  typedef enum logic [1:0] {
    GRANT_NONE = 2'd0,
    GRANT_CPU  = 2'd1,
    GRANT_CTL  = 2'd2
  } ld_grant_e;

endpackage

// File: rtl/burst_beat_ctr.sv
// Holds the captured low start bits and the running beat number.
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [BEAT_W-1:0] start_d,
  output logic [BEAT_W-1:0] start_q,
  output logic [BEAT_W-1:0] beat_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= start_d;
      beat_q  <= '0;
    end else if (step) begin
      beat_q  <= beat_q + BEAT_W'(1);
    end
  end

endmodule

// File: rtl/burst_seq_map.sv
// Maps start bits and beat number onto the issued low address bits.
module burst_seq_map #(
  parameter int BEAT_W = 2
) (
  input  burst_addr_pkg::seq_order_e order,
  input  logic [BEAT_W-1:0]          start,
  input  logic [BEAT_W-1:0]          beat,
  output logic [BEAT_W-1:0]          low
);
  import burst_addr_pkg::*;

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  // Linear: modular sum, the carry out of the top bit is dropped
  assign lin_low = start + beat;

  // Interleaved: per-bit XOR
  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_low[b] = start[b] ^ beat[b];
  end

  always_comb begin
    unique case (order)
      SEQ_LINEAR:     low = lin_low;
      SEQ_INTERLEAVE: low = ilv_low;
      default:        low = ilv_low;
    endcase
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 15,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ld_n,
  input  logic              ctl_ld_n,
  input  logic              adv_n,
  input  logic              order_lin_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  import burst_addr_pkg::*;

  localparam int UPPER_W = ADDR_W - BEAT_W;

  ld_grant_e          grant;
  logic               load;
  logic               step;
  seq_order_e         order;
  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  start_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [BEAT_W-1:0]  low;

  // Fixed priority: processor strobe first
  always_comb begin
    if (!cpu_ld_n)      grant = GRANT_CPU;
    else if (!ctl_ld_n) grant = GRANT_CTL;
    else                grant = GRANT_NONE;
  end

  assign load  = (grant != GRANT_NONE);
  assign step  = !adv_n;
  assign order = order_lin_n ? SEQ_INTERLEAVE : SEQ_LINEAR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    upper_q <= '0;
    else if (load) upper_q <= addr_i[ADDR_W-1:BEAT_W];
  end

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .start_d (addr_i[BEAT_W-1:0]),
    .start_q (start_q),
    .beat_q  (beat_q)
  );

  burst_seq_map #(.BEAT_W(BEAT_W)) u_map (
    .order (order),
    .start (start_q),
    .beat  (beat_q),
    .low   (low)
  );

  assign addr_o = {upper_q, low};

endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
  parameter int ADDR_W = 15,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ld_n,
  input logic              ctl_ld_n,
  input logic              adv_n,
  input logic              order_lin_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);

  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (addr_o == '0) else $error("R1 addr_o not zero in reset");
    end
  end

  p_load_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ld_n |=> addr_o == $past(addr_i));

  p_load_ctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ld_n |=> addr_o == $past(addr_i));

  p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ld_n && ctl_ld_n) |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ld_n && ctl_ld_n && adv_n) |=>
      (order_lin_n != $past(order_lin_n)) || (addr_o == $past(addr_o)));

  p_lin_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ld_n && ctl_ld_n && !adv_n && !order_lin_n) |=>
      order_lin_n || (addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + BEAT_W'(1)));

  p_ilv_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ld_n && ctl_ld_n && !adv_n && order_lin_n) |=>
      !order_lin_n || (addr_o[0] != $past(addr_o[0])));

endmodule

bind burst_addr_gen burst_addr_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_ld_n    (cpu_ld_n),
  .ctl_ld_n    (ctl_ld_n),
  .adv_n       (adv_n),
  .order_lin_n (order_lin_n),
  .addr_i      (addr_i),
  .addr_o      (addr_o)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 15;
  localparam int WATCHDOG   = 5000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_ld_n = 1'b1;
  logic          ctl_ld_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_lin_n = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state
  int m_upper = 0;
  int m_start = 0;
  int m_beat  = 0;
  int last_kind = 0;  // 0 idle, 1 cpu load, 2 ctl load, 3 both, 4 step
  int prev_kind = 0;
  int last_upper = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .cpu_ld_n(cpu_ld_n), .ctl_ld_n(ctl_ld_n),
    .adv_n(adv_n), .order_lin_n(order_lin_n), .addr_i(addr_i), .addr_o(addr_o)
  );

  function automatic int exp_addr();
    int lo;
    if (order_lin_n) lo = m_start ^ m_beat;
    else             lo = (m_start + m_beat) % 4;
    return (m_upper << 2) | lo;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    string tag;
    bit loaded = (last_kind >= 1 && last_kind <= 3);
    if (loaded && prev_kind >= 1 && prev_kind <= 3) tag = "R9";
    else if (last_kind == 1) tag = "R2";
    else if (last_kind == 2 || last_kind == 3) tag = "R3";
    else if (last_kind == 4 && m_beat == 0) tag = "R8";
    else if (last_kind == 4) tag = order_lin_n ? "R7" : "R6";
    else tag = "R5";
    check(tag, int'(addr_o), exp_addr());
    if (!loaded) check("R4", int'(addr_o >> 2), last_upper);
  endtask

  // Compare current output, then drive the next edge's inputs and advance the model
  task automatic cyc(bit c, bit k, bit v, bit o, int a);
    @(negedge clk);
    compare();
    last_upper = m_upper;
    prev_kind = last_kind;
    cpu_ld_n = c; ctl_ld_n = k; adv_n = v; order_lin_n = o; addr_i = AW'(a);
    if (!c || !k) begin
      m_upper = (a >> 2) & ((1 << (AW-2)) - 1);
      m_start = a & 3;
      m_beat  = 0;
      last_kind = (!c && !k) ? 3 : (!c ? 1 : 2);
    end else if (!v) begin
      m_beat = (m_beat + 1) % 4;
      last_kind = 4;
    end else begin
      last_kind = 0;
    end
  endtask

  initial begin
    int w = 0;
    while (!done && w < WATCHDOG) begin
      @(posedge clk);
      w++;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit o;
    bit c;
    bit k;
    bit v;
    repeat (3) begin
      @(negedge clk);
      check("R1", int'(addr_o), 0);
    end
    rst_n = 1'b1;

    // Full bursts from every start offset in both orders, one wrap each (R6 R7 R8)
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        cyc(1'b0, 1'b1, 1'b1, ord[0], 'h5a50 | s);
        for (int n = 0; n < 6; n++) cyc(1'b1, 1'b1, 1'b0, ord[0], 0);
      end
    end

    // Strobe with step low on the same edge, both strobes together (R3)
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 'h1233);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 'h7ff2);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 0);

    // Back-to-back loads (R9)
    for (int i = 0; i < 6; i++) cyc(i[0], ~i[0], 1'b0, 1'b1, 'h0101 * (i + 3));

    // Idle gaps inside a burst and order flips mid-burst (R5)
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 'h2aa1);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 0);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 0);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 0);

    // Mixed traffic
    o = 1'b1;
    for (int i = 0; i < 400; i++) begin
      if (i % 53 == 0) o = ~o;
      c = ($urandom % 7) != 0;
      k = ($urandom % 6) != 0;
      v = ($urandom % 3) == 0;
      cyc(c, k, v, o, int'($urandom));
    end
    cyc(1'b1, 1'b1, 1'b1, o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule